// File: doc/BRIEF.md
# Erase/Program Status Byte Generator

This block supplies the byte a microcontroller reads back from a non-volatile memory while an embedded erase or program operation is in progress. While the modelled operation is busy, the read data path carries a status byte instead of array contents. Software can poll that byte in two ways. It can compare the top bit against the value it wrote, or it can watch a bit that flips on every read until the operation ends.

The block models the operation itself. A start pulse loads an operation length and a cycle limit, and a counter runs down the length. If the limit is reached first, or an external fault is flagged, the operation latches an error and stays busy until an abort command clears it. For erase operations, a window counter tracks the period in which further sector-erase commands may be queued. Each such command reloads the window, and the byte reports when the window has closed. For EEPROM operations, only the polling and toggle bits carry meaning. All other bits read zero.

Top module: `sts_status_gen`

## Requirements
- R1: After reset the block is idle (`busy` = 0), and `dout` equals `array_data`.
- R2: A cycle with `op_start` = 1 and `busy` = 0 starts an operation. When 1 <= `op_len` <= `cyc_limit`, `busy` is high for exactly `op_len` cycles after the start edge. A start with `op_len` = 0 leaves the block idle. An `op_start` while busy has no effect on the data, the length or the mode.
- R3: While `busy` = 0, `dout` equals `array_data`. While `busy` = 1, `dout` carries the status byte.
- R4: Bit 7 of the status byte is the complement of bit 7 of `wr_data` captured at the start.
- R5: Bit 6 of the status byte reads 0 after a start and inverts after every cycle in which `rd_strobe` is high while busy.
- R6: Bit 5 (error) is set in either of two cases. The first is `cyc_limit` busy cycles passing without completion (`op_len` > `cyc_limit`). The second is `err_in` being high in a busy cycle, in which case the bit reads 1 from the next cycle. Once set, the error holds and `busy` stays high until `abort_cmd`.
- R7: `abort_cmd` ends any operation within one cycle and clears the error and toggle state.
- R8: For erase operations, bit 3 reads 1 once `WINDOW` busy cycles have passed since the start or since the last `sector_add`. A `sector_add` while the window is open reloads it. For program operations, bit 3 is 0.
- R9: For EEPROM operations (`op_eeprom` = 1 at the start), bits 5 to 0 of the status byte are 0.
- R10: Bits 4, 2, 1 and 0 of the status byte are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Start pulse for a modelled operation |
| op_len | input | CNT_W | Operation duration in cycles |
| cyc_limit | input | CNT_W | Busy cycles allowed before an error is declared |
| op_erase | input | 1 | 1 = erase operation, 0 = program |
| op_eeprom | input | 1 | 1 = EEPROM target, 0 = Flash |
| wr_data | input | 8 | Data byte being programmed |
| err_in | input | 1 | External fault indication |
| sector_add | input | 1 | Additional sector-erase command |
| rd_strobe | input | 1 | Status read strobe |
| abort_cmd | input | 1 | Reset instruction: abort and clear error |
| array_data | input | 8 | Memory array read data |
| busy | output | 1 | Operation in progress |
| dout | output | 8 | Read data: status byte when busy, array data otherwise |

## Verification
The hardest condition to reach is the interaction of a limit overrun with the toggle and window bits. In that case the operation neither completes nor aborts, while reads keep flipping bit 6 and the erase window closes underneath it. The bench sweeps every pairing of a small operation length against a small cycle limit, in all four erase/EEPROM modes, with a different read pattern for each run. It predicts each bit from the cycle index alone. Dedicated runs cover a window reload by `sector_add`, a fault raised through `err_in`, and a start arriving mid-operation.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int P_POLL = 7;
    localparam int P_TOG  = 6;
    localparam int P_ERR  = 5;
    localparam int P_TMO  = 3;
    localparam logic [7:0] DC_MASK = 8'h17;
endpackage

// File: rtl/sts_op_timer.sv
module sts_op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             err_in,
    input  logic [CNT_W-1:0] op_len,
    input  logic [CNT_W-1:0] cyc_limit,
    output logic             busy,
    output logic             err,
    output logic             accept
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             err;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] el;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        accept = start && !tmr_q.busy && !abort;
        if (abort) begin
            tmr_d = '0;
        end else if (accept) begin
            tmr_d.busy = (op_len != '0);
            tmr_d.err  = 1'b0;
            tmr_d.rem  = op_len;
            tmr_d.el   = '0;
        end else if (tmr_q.busy && !tmr_q.err) begin
            if (err_in) begin
                tmr_d.err = 1'b1;
            end else if (tmr_q.rem == ONE) begin
                tmr_d.busy = 1'b0;
            end else if (tmr_q.el + ONE == cyc_limit) begin
                tmr_d.err = 1'b1;
            end else begin
                tmr_d.rem = tmr_q.rem - ONE;
                tmr_d.el  = tmr_q.el + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign err  = tmr_q.err;

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.err && !abort |=> tmr_q.err && tmr_q.busy);
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !tmr_q.busy && !tmr_q.err);
endmodule

// File: rtl/sts_erase_window.sv
module sts_erase_window #(
    parameter int WINDOW = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic is_erase,
    input  logic busy,
    input  logic sector_add,
    input  logic abort,
    output logic closed
);
    localparam int WIN_W = $clog2(WINDOW + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW);

    typedef struct packed {
        logic             active;
        logic [WIN_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (abort) begin
            win_d = '0;
        end else if (start_acc) begin
            win_d.active = is_erase;
            win_d.cnt    = WIN_LOAD;
        end else if (win_q.active && busy) begin
            if (sector_add && win_q.cnt != '0) win_d.cnt = WIN_LOAD;
            else if (win_q.cnt != '0)          win_d.cnt = win_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign closed = win_q.active && (win_q.cnt == '0);

    assert_window_stays_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        closed && !start_acc && !abort |=> closed);
endmodule

// File: rtl/sts_status_gen.sv
module sts_status_gen
    import sts_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WINDOW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic [CNT_W-1:0] op_len,
    input  logic [CNT_W-1:0] cyc_limit,
    input  logic             op_erase,
    input  logic             op_eeprom,
    input  logic [7:0]       wr_data,
    input  logic             err_in,
    input  logic             sector_add,
    input  logic             rd_strobe,
    input  logic             abort_cmd,
    input  logic [7:0]       array_data,
    output logic             busy,
    output logic [7:0]       dout
);
    typedef struct packed {
        logic tog;
        logic data7;
        logic ee;
    } fmt_t;

    fmt_t st_d, st_q;
    logic accept, err, closed;
    logic [7:0] status;

    sts_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .abort     (abort_cmd),
        .err_in    (err_in),
        .op_len    (op_len),
        .cyc_limit (cyc_limit),
        .busy      (busy),
        .err       (err),
        .accept    (accept)
    );

    sts_erase_window #(.WINDOW(WINDOW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_acc  (accept),
        .is_erase   (op_erase),
        .busy       (busy),
        .sector_add (sector_add),
        .abort      (abort_cmd),
        .closed     (closed)
    );

    always_comb begin
        st_d = st_q;
        if (abort_cmd) begin
            st_d.tog = 1'b0;
        end else if (accept) begin
            st_d.tog   = 1'b0;
            st_d.data7 = wr_data[7];
            st_d.ee    = op_eeprom;
        end else if (busy && rd_strobe) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status         = '0;
        status[P_POLL] = ~st_q.data7;
        status[P_TOG]  = st_q.tog;
        if (!st_q.ee) begin
            status[P_ERR] = err;
            status[P_TMO] = closed;
        end
        dout = busy ? status : array_data;
    end

    assert_dq7_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_len != '0 |=> busy && (dout[7] == !$past(wr_data[7])));
    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_strobe && !abort_cmd |=> st_q.tog != $past(st_q.tog));
    assert_idle_toggle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !accept && !abort_cmd |=> $stable(st_q.tog));
    assert_ee_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && st_q.ee |-> dout[5:0] == 6'd0);
    assert_dontcare_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dout & DC_MASK) == 8'd0);
endmodule

// File: tb/sts_status_gen_bench.sv
module sts_status_gen_bench;
    localparam int CW  = 8;
    localparam int WIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_erase = 0, op_eeprom = 0, err_in = 0;
    logic sector_add = 0, rd_strobe = 0, abort_cmd = 0;
    logic [CW-1:0] op_len = '0, cyc_limit = '0;
    logic [7:0] wr_data = '0, array_data = 8'h5A;
    logic busy;
    logic [7:0] dout;
    int tests = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    sts_status_gen #(.CNT_W(CW), .WINDOW(WIN)) u_sts_status_gen (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_len(op_len),
        .cyc_limit(cyc_limit), .op_erase(op_erase), .op_eeprom(op_eeprom),
        .wr_data(wr_data), .err_in(err_in), .sector_add(sector_add),
        .rd_strobe(rd_strobe), .abort_cmd(abort_cmd), .array_data(array_data),
        .busy(busy), .dout(dout)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // check the full byte at negedge j of an operation
    task automatic check_byte(input logic b, input logic [7:0] data, input logic tog,
                              input logic er, input logic cl, input logic ee,
                              input logic [7:0] arr);
        chk("R2 busy", {7'd0, busy}, {7'd0, b});
        if (!b) begin
            chk("R3 passthrough", dout, arr);
        end else begin
            chk("R4 poll bit", {7'd0, dout[7]}, {7'd0, ~data[7]});
            chk("R5 toggle bit", {7'd0, dout[6]}, {7'd0, tog});
            chk("R6 error bit", {7'd0, dout[5]}, {7'd0, er & ~ee});
            chk("R8 window bit", {7'd0, dout[3]}, {7'd0, cl & ~ee});
            chk("R10 zero bits", dout & 8'h17, 8'h00);
            if (ee) chk("R9 eeprom low bits", {2'd0, dout[5:0]}, 8'h00);
        end
    endtask

    task automatic begin_op(input int len, input int lim, input logic [7:0] data,
                            input logic er, input logic ee);
        @(negedge clk);
        op_start = 1; op_len = CW'(len); cyc_limit = CW'(lim);
        wr_data = data; op_erase = er; op_eeprom = ee;
        array_data = data ^ 8'h3C;
        @(negedge clk);
        op_start = 0;
    endtask

    task automatic finish_op();
        rd_strobe = 0; sector_add = 0; err_in = 0;
        abort_cmd = 1;
        @(negedge clk);
        abort_cmd = 0;
        chk("R7 abort idles", {7'd0, busy}, 8'd0);
    endtask

    task automatic run_sweep(input int len, input int lim, input int mode);
        logic [7:0] data;
        logic [9:0] rmask;
        logic tog;
        logic er, ee;
        data  = 8'(len * 37 + lim * 11 + mode * 5);
        rmask = 10'(len * 91 + lim * 13 + mode);
        er = mode[0]; ee = mode[1];
        tog = 0;
        begin_op(len, lim, data, er, ee);
        for (int j = 0; j < 10; j++) begin
            logic b, e;
            b = (len > lim) ? 1'b1 : (j < len);
            e = (len > lim) && (j >= lim);
            check_byte(b, data, tog, e, er && (j >= WIN), ee, data ^ 8'h3C);
            rd_strobe = rmask[j];
            if (b && rmask[j]) tog = ~tog;
            // R2: start during a busy operation must be ignored
            op_start = (j == 1 && len >= 3);
            wr_data  = op_start ? ~data : data;
            op_len   = op_start ? CW'(15) : CW'(len);
            @(negedge clk);
        end
        op_start = 0;
        finish_op();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {7'd0, busy}, 8'd0);
        chk("R1 reset passthrough", dout, 8'h5A);
        rst_n = 1;
        @(negedge clk);
        array_data = 8'hC3;
        #1 chk("R3 idle passthrough", dout, 8'hC3);

        for (int len = 1; len <= 6; len++)
            for (int lim = 1; lim <= 6; lim++)
                for (int mode = 0; mode < 4; mode++)
                    run_sweep(len, lim, mode);

        // R2: zero-length start stays idle
        begin_op(0, 5, 8'h80, 0, 0);
        chk("R2 zero length idle", {7'd0, busy}, 8'd0);
        chk("R3 zero length passthrough", dout, 8'h80 ^ 8'h3C);

        // R8: sector_add at j=2 reloads the window; closes at j=7
        begin_op(20, 30, 8'h01, 1, 0);
        for (int j = 0; j < 10; j++) begin
            check_byte(1'b1, 8'h01, 1'b0, 1'b0, (j < 3) ? (j >= WIN) : (j >= 7), 1'b0, 8'h3D);
            sector_add = (j == 2);
            @(negedge clk);
        end
        finish_op();

        // R6: external fault at j=2 sets error at j=3, operation stays busy
        begin_op(5, 30, 8'hFF, 0, 0);
        for (int j = 0; j < 10; j++) begin
            check_byte(1'b1, 8'hFF, 1'b0, j >= 3, 1'b0, 1'b0, 8'hC3);
            err_in = (j == 2);
            @(negedge clk);
        end
        finish_op();
        // R7: after abort the error and toggle read clear on a new operation
        begin_op(3, 5, 8'h00, 0, 0);
        check_byte(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
        finish_op();
        summary();
    end
endmodule